// File: doc/BRIEF.md
# Target Time Trigger

This block watches a running seconds/nanoseconds time value supplied by a separate time counter and compares it with a target time held in two registers of its own, one for seconds and one for nanoseconds. Software writes the two target fields with separate accesses, arms the trigger, and waits. When the running time reaches the target while the trigger is armed, the block raises a sticky hit flag and disarms itself, so each arming yields exactly one hit.

The interrupt line is the hit flag gated by a mask register. Because the target fields are not written in one access, a half-written target can look like a time already passed. The intended software sequence is: mask, rewrite both fields, clear any stale hit, arm, unmask. While masked, the interrupt line stays low whatever the comparison does. The hit flag is cleared by writing one to a clear strobe.

Top module: `ptp_tgt_trig`

## Requirements
- R1: After reset the trigger is disarmed, the hit flag and interrupt are low, the mask is set and both target fields are zero.
- R2: The target is reached when the current seconds exceed the target seconds, or equal them with current nanoseconds greater than or equal to the target nanoseconds.
- R3: When armed and the target is reached at a clock edge, the hit flag is set and the trigger is disarmed by that edge, so a still-reached target produces no further hit until rearmed.
- R4: While disarmed the hit flag never becomes set, whatever the time and target values.
- R5: A disarm strobe clears the armed state and wins over a simultaneous arm strobe; an armed trigger disarmed before the target is reached never hits.
- R6: The interrupt output is high exactly when the hit flag is set and the mask register is clear; the mask register follows its write strobe one clock later.
- R7: The clear strobe clears the hit flag at the next edge, except when a new hit occurs at that same edge, in which case the flag stays set.
- R8: Arming with a target already in the past sets the hit flag at the second clock edge after the arm strobe is sampled (armed after the first edge, hit after the second).
- R9: Each target field is loaded from its write data at the edge where its write strobe is high, independently of the other field.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_sec | input | SEC_W | Current seconds from the time counter |
| now_ns | input | NS_W | Current nanoseconds from the time counter |
| sec_wr | input | 1 | Write strobe for target seconds |
| sec_wdata | input | SEC_W | Target seconds write data |
| ns_wr | input | 1 | Write strobe for target nanoseconds |
| ns_wdata | input | NS_W | Target nanoseconds write data |
| arm_set | input | 1 | Arm strobe |
| arm_clr | input | 1 | Disarm strobe |
| mask_wr | input | 1 | Mask register write strobe |
| mask_wdata | input | 1 | Mask value (1 = interrupt suppressed) |
| hit_clr | input | 1 | Write-one-to-clear strobe for the hit flag |
| tgt_sec | output | SEC_W | Target seconds register |
| tgt_ns | output | NS_W | Target nanoseconds register |
| armed | output | 1 | Trigger armed state |
| hit | output | 1 | Sticky hit flag |
| irq | output | 1 | Masked interrupt |

## Verification
The assertions take the time inputs as plain values that may jump arbitrarily between cycles; they do not rely on the counter moving forward, and the nanoseconds input is assumed below one billion only in the sense that the comparison is unsigned over the full field. They take the strobes as one-cycle pulses sampled at the rising edge. The stimulus drives every input at the falling edge, holds the time constant while arming so that the hit timing is fixed, and sweeps the current time across a window of seconds and nanoseconds around several targets, including nanoseconds at zero and at the largest value in a second.

// File: rtl/ptp_tgt_trig.sv
module ptp_tgt_trig #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] now_sec,
  input  logic [NS_W-1:0]  now_ns,
  input  logic             sec_wr,
  input  logic [SEC_W-1:0] sec_wdata,
  input  logic             ns_wr,
  input  logic [NS_W-1:0]  ns_wdata,
  input  logic             arm_set,
  input  logic             arm_clr,
  input  logic             mask_wr,
  input  logic             mask_wdata,
  input  logic             hit_clr,
  output logic [SEC_W-1:0] tgt_sec,
  output logic [NS_W-1:0]  tgt_ns,
  output logic             armed,
  output logic             hit,
  output logic             irq
);

  logic mask_q;
  logic reached;
  logic fire;

  assign reached = (now_sec > tgt_sec) || ((now_sec == tgt_sec) && (now_ns >= tgt_ns));
  assign fire    = armed && reached;
  assign irq     = hit && !mask_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_sec <= '0;
      tgt_ns  <= '0;
      mask_q  <= 1'b1;
    end else begin
      if (sec_wr)  tgt_sec <= sec_wdata;
      if (ns_wr)   tgt_ns  <= ns_wdata;
      if (mask_wr) mask_q  <= mask_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       armed <= 1'b0;
    else if (arm_clr) armed <= 1'b0;
    else if (arm_set) armed <= 1'b1;
    else if (fire)    armed <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       hit <= 1'b0;
    else if (fire)    hit <= 1'b1;
    else if (hit_clr) hit <= 1'b0;
  end

endmodule

module ptp_tgt_trig_chk #(
  parameter int SEC_W = 48,
  parameter int NS_W  = 30
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SEC_W-1:0] now_sec,
  input logic [NS_W-1:0]  now_ns,
  input logic             sec_wr,
  input logic [SEC_W-1:0] sec_wdata,
  input logic             ns_wr,
  input logic [NS_W-1:0]  ns_wdata,
  input logic             arm_set,
  input logic             arm_clr,
  input logic             hit_clr,
  input logic [SEC_W-1:0] tgt_sec,
  input logic [NS_W-1:0]  tgt_ns,
  input logic             armed,
  input logic             hit,
  input logic             irq,
  input logic             mask_q
);
  logic due;
  assign due = (now_sec > tgt_sec) || ((now_sec == tgt_sec) && (now_ns >= tgt_ns));

  a_r3_hit_and_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && due && !arm_set) |=> (hit && !armed));
  a_r4_no_hit_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> !$rose(hit));
  a_r5_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    arm_clr |=> !armed);
  a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq);
  a_r6_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> hit);
  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_clr && !(armed && due)) |=> !hit);
  a_r9_sec_load: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr |=> (tgt_sec == $past(sec_wdata)));
  a_r9_ns_load: assert property (@(posedge clk) disable iff (!rst_n)
    ns_wr |=> (tgt_ns == $past(ns_wdata)));
endmodule

bind ptp_tgt_trig ptp_tgt_trig_chk #(.SEC_W(SEC_W), .NS_W(NS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .now_sec(now_sec), .now_ns(now_ns),
  .sec_wr(sec_wr), .sec_wdata(sec_wdata), .ns_wr(ns_wr), .ns_wdata(ns_wdata),
  .arm_set(arm_set), .arm_clr(arm_clr), .hit_clr(hit_clr),
  .tgt_sec(tgt_sec), .tgt_ns(tgt_ns), .armed(armed), .hit(hit), .irq(irq),
  .mask_q(mask_q)
);

// File: tb/ptp_tgt_trig_test.sv
module ptp_tgt_trig_test;
  localparam int SW = 48;
  localparam int NW = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SW-1:0] now_sec = '0;
  logic [NW-1:0] now_ns = '0;
  logic sec_wr = 0, ns_wr = 0, arm_set = 0, arm_clr = 0, mask_wr = 0, mask_wdata = 0, hit_clr = 0;
  logic [SW-1:0] sec_wdata = '0;
  logic [NW-1:0] ns_wdata = '0;
  logic [SW-1:0] tgt_sec;
  logic [NW-1:0] tgt_ns;
  logic armed, hit, irq;

  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ptp_tgt_trig #(.SEC_W(SW), .NS_W(NW)) uut (
    .clk(clk), .rst_n(rst_n), .now_sec(now_sec), .now_ns(now_ns),
    .sec_wr(sec_wr), .sec_wdata(sec_wdata), .ns_wr(ns_wr), .ns_wdata(ns_wdata),
    .arm_set(arm_set), .arm_clr(arm_clr), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .hit_clr(hit_clr), .tgt_sec(tgt_sec), .tgt_ns(tgt_ns),
    .armed(armed), .hit(hit), .irq(irq)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic set_target(input longint s, input longint n);
    sec_wr = 1; sec_wdata = SW'(s); tick(); sec_wr = 0;
    ns_wr = 1; ns_wdata = NW'(n); tick(); ns_wr = 0;
  endtask

  task automatic set_mask(input bit m);
    mask_wr = 1; mask_wdata = m; tick(); mask_wr = 0; mask_wdata = 0;
  endtask

  task automatic clear_hit();
    hit_clr = 1; tick(); hit_clr = 0;
  endtask

  task automatic disarm();
    arm_clr = 1; tick(); arm_clr = 0;
  endtask

  task automatic arm_expect(input bit exp, input string req);
    arm_set = 1; tick(); arm_set = 0;
    chk(req, armed, 1);
    chk(req, hit, 0);
    tick();
    chk(req, hit, exp);
    chk(req, armed, !exp);
    if (exp) clear_hit(); else disarm();
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    longint ts [4] = '{5, 5, 9, 0};
    longint tn [4] = '{500, 0, 999999999, 2};
    tick(); tick();
    rst_n = 1; tick();
    // R1 reset state
    chk("R1", armed, 0); chk("R1", hit, 0); chk("R1", irq, 0);
    chk("R1", tgt_sec, 0); chk("R1", tgt_ns, 0);
    clear_hit(); set_mask(0); set_mask(1);

    // R9 independent field loads
    sec_wr = 1; sec_wdata = 48'd77; tick(); sec_wr = 0;
    chk("R9", tgt_sec, 77); chk("R9", tgt_ns, 0);
    ns_wr = 1; ns_wdata = 30'd123; tick(); ns_wr = 0;
    chk("R9", tgt_sec, 77); chk("R9", tgt_ns, 123);

    // R2/R8 sweep around several targets
    for (int t = 0; t < 4; t++) begin
      set_target(ts[t], tn[t]);
      for (int ds = -2; ds <= 2; ds++) begin
        for (int dn = -2; dn <= 2; dn++) begin
          longint cs = ts[t] + ds;
          longint cn = tn[t] + dn;
          bit e;
          if (cs < 0 || cn < 0) continue;
          e = (cs > ts[t]) || (cs == ts[t] && cn >= tn[t]);
          now_sec = SW'(cs); now_ns = NW'(cn);
          arm_expect(e, "R2");
        end
      end
    end

    // R8 exact hit timing with past target
    set_target(3, 10); now_sec = 4; now_ns = 0;
    arm_expect(1, "R8");

    // R3 one-shot: target still reached, no rehit after clear
    arm_set = 1; tick(); arm_set = 0; tick();
    chk("R3", hit, 1); chk("R3", armed, 0);
    clear_hit();
    for (int i = 0; i < 5; i++) tick();
    chk("R3", hit, 0);

    // R4 disarmed never hits
    now_sec = 100; tick(); tick();
    chk("R4", hit, 0); chk("R4", armed, 0);

    // R5 disarm before reach, and clear wins over set
    now_sec = 2; now_ns = 0;
    arm_set = 1; tick(); arm_set = 0;
    disarm();
    now_sec = 50; tick(); tick();
    chk("R5", hit, 0); chk("R5", armed, 0);
    arm_set = 1; arm_clr = 1; tick(); arm_set = 0; arm_clr = 0;
    chk("R5", armed, 0); tick();
    chk("R5", hit, 0);

    // R6 masking with a half-written target
    set_mask(1);
    set_target(1000, 0); now_sec = 20;
    arm_set = 1; tick(); arm_set = 0;
    sec_wr = 1; sec_wdata = 10; tick(); sec_wr = 0;
    tick();
    chk("R6", hit, 1); chk("R6", irq, 0);
    mask_wr = 1; mask_wdata = 0; tick(); mask_wr = 0;
    chk("R6", irq, 1);
    clear_hit();
    chk("R6", irq, 0);

    // R7 clear vs simultaneous hit
    set_target(1, 0); now_sec = 5;
    arm_set = 1; tick(); arm_set = 0;
    hit_clr = 1; tick(); hit_clr = 0;
    chk("R7", hit, 1); chk("R7", irq, 1);
    clear_hit();
    chk("R7", hit, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule